// File: doc/BRIEF.md
# Serial Selector Pattern Classifier for Bit Extract and Bit Deposit

This block watches a bit-shuffle selector vector as it streams in, one entry per cycle, and decides whether it has the shape of a bit-extract or a bit-deposit operation. The vector has N entries. Each entry is an index in 0..2N-1. An index below N picks a bit from a data word. An index of N or above picks a bit from a word that is known to be all zeros. A code generator or a shuffle-lowering unit uses the verdict to replace a general bit shuffle with one compact extract or deposit step, and the block also returns the N-bit mask that this step needs.

Entries arrive with `in_valid`, and are tagged with `in_first` and `in_last`. Two trackers, one for each pattern, update on every accepted entry. A length counter confirms that exactly N entries were seen. A three-state controller (ST_IDLE, ST_RUN, ST_DONE) frames the vector. Its transitions are as follows:
- T_START: ST_IDLE to ST_RUN on a first entry that is not also last.
- T_SINGLE: ST_IDLE or ST_DONE to ST_DONE on an entry that is both first and last.
- T_ENTRY: ST_RUN stays in ST_RUN on an entry that is not last.
- T_RESTART: ST_RUN stays in ST_RUN on a first entry, and the classification starts over.
- T_FINISH: ST_RUN to ST_DONE on a last entry.
- T_RETIRE: ST_DONE to ST_IDLE when no first entry arrives.
- T_RELOAD: ST_DONE to ST_RUN on a first entry that is not last.

The result is shown for the single cycle spent in ST_DONE.

Top module: `selidx_classifier`

## Requirements
- R1: An index with bit LW set (value N or more) is a zero selector. A vector whose data indices (below N) form a strictly increasing run, followed only by zero selectors of any value N..2N-1, sets `is_extract`. In the mask, bit k is 1 exactly when k appeared in that run. For N=32, <0,2,5,6,32,...> gives mask 0x65.
- R2: A data index that is equal to or below the previous data index (a repeat or a swap), or a data index that comes after any zero selector, clears `is_extract`.
- R3: A vector whose data indices appear as 0,1,2,... in that order, interleaved in any way with zero selectors that equal exactly N, sets `is_deposit`. In the mask, bit i is 1 exactly when entry i (counted from 0 at the first entry) is a data index.
- R4: A data index that skips or repeats a value in the 0,1,2,... order, or a zero selector other than exactly N, clears `is_deposit`.
- R5: A vector of N copies of index N sets both flags with mask 0. The identity vector <0,1,...,N-1> sets both flags with an all-ones mask. Whenever both flags are set, the mask is a contiguous run of ones starting at bit 0.
- R6: A vector with more or fewer than N entries between first and last sets neither flag.
- R7: `result_valid` is 1 for the one cycle after the clock edge that accepts a last entry. `is_extract`, `is_deposit` and `mask` are 0 when `result_valid` is 0, and `mask` is 0 when neither flag is set. When both flags are set, the two masks agree.
- R8: A first entry in the middle of a vector discards what came before it. Cycles with `in_valid` low are ignored. Valid entries that arrive while no vector is open (before a first entry) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An entry is present this cycle |
| in_first | input | 1 | This entry is entry 0 of a vector |
| in_last | input | 1 | This entry ends the vector |
| in_index | input | $clog2(2N) | Selector index, 0..2N-1 |
| result_valid | output | 1 | Verdict and mask are valid this cycle |
| is_extract | output | 1 | The vector matched the extract pattern |
| is_deposit | output | 1 | The vector matched the deposit pattern |
| mask | output | N | Extract or deposit mask, 0 when there is no match |

## Verification
Four things are checked on every cycle:
- A verdict appears only after a last entry was accepted.
- The verdict lasts one cycle, unless another single-entry vector closes right behind it.
- The outputs stay at zero outside the verdict cycle.
- A dual match always carries a mask that is a low run of ones.

Whether a particular vector is classified correctly can only be shown by the bench's scenarios. These are random masks turned into both vector shapes, the same vectors corrupted by a swap, a repeat, a gap or a non-canonical zero, wrong lengths, and restarts or idle gaps in the middle of a vector.

// File: rtl/selidx_pkg.sv
package selidx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } cls_state_e;
endpackage

// File: rtl/selidx_extract_track.sv
// Tracks the extract grammar: increasing data run, then zero tail.
module selidx_extract_track #(
    parameter int N  = 32,
    parameter int LW = $clog2(N),
    parameter int IW = LW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          restart,
    input  logic [IW-1:0] idx,
    output logic          ok,
    output logic [N-1:0]  mask
);
    logic          ok_q, tail_q, seen_q;
    logic [LW-1:0] prev_q;
    logic [N-1:0]  mask_q;
    logic          ok_n, tail_n, seen_n;
    logic [LW-1:0] prev_n;
    logic [N-1:0]  mask_n;

    always_comb begin
        ok_n   = ok_q;
        tail_n = tail_q;
        seen_n = seen_q;
        prev_n = prev_q;
        mask_n = mask_q;
        if (take) begin
            if (restart) begin
                ok_n   = 1'b1;
                tail_n = 1'b0;
                seen_n = 1'b0;
                prev_n = '0;
                mask_n = '0;
            end
            if (!idx[IW-1]) begin
                if (tail_n || (seen_n && idx[LW-1:0] <= prev_n)) begin
                    ok_n = 1'b0;
                end else begin
                    mask_n[idx[LW-1:0]] = 1'b1;
                    prev_n = idx[LW-1:0];
                    seen_n = 1'b1;
                end
            end else begin
                tail_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_q   <= 1'b0;
            tail_q <= 1'b0;
            seen_q <= 1'b0;
            prev_q <= '0;
            mask_q <= '0;
        end else begin
            ok_q   <= ok_n;
            tail_q <= tail_n;
            seen_q <= seen_n;
            prev_q <= prev_n;
            mask_q <= mask_n;
        end
    end

    assign ok   = ok_q;
    assign mask = mask_q;
endmodule

// File: rtl/selidx_deposit_track.sv
// Tracks the deposit grammar: data indices 0,1,2.. interleaved with index N.
module selidx_deposit_track #(
    parameter int N  = 32,
    parameter int LW = $clog2(N),
    parameter int IW = LW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          restart,
    input  logic [IW-1:0] idx,
    input  logic [LW-1:0] pos,
    output logic          ok,
    output logic [N-1:0]  mask
);
    localparam logic [IW-1:0] ZERO_SEL = IW'(N);

    logic          ok_q, ok_n;
    logic [LW:0]   nxt_q, nxt_n;
    logic [N-1:0]  mask_q, mask_n;

    always_comb begin
        ok_n   = ok_q;
        nxt_n  = nxt_q;
        mask_n = mask_q;
        if (take) begin
            if (restart) begin
                ok_n   = 1'b1;
                nxt_n  = '0;
                mask_n = '0;
            end
            if (!idx[IW-1]) begin
                if ({1'b0, idx[LW-1:0]} != nxt_n) ok_n = 1'b0;
                mask_n[pos] = 1'b1;
                nxt_n = nxt_n + 1'b1;
            end else if (idx != ZERO_SEL) begin
                ok_n = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_q   <= 1'b0;
            nxt_q  <= '0;
            mask_q <= '0;
        end else begin
            ok_q   <= ok_n;
            nxt_q  <= nxt_n;
            mask_q <= mask_n;
        end
    end

    assign ok   = ok_q;
    assign mask = mask_q;
endmodule

// File: rtl/selidx_len_count.sv
// Position of the current entry and an exact-length flag.
module selidx_len_count #(
    parameter int N  = 32,
    parameter int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          restart,
    output logic [LW-1:0] pos,
    output logic          fits
);
    localparam logic [LW:0] CNT_MAX  = (LW+1)'(N);
    localparam logic [LW:0] CNT_LAST = (LW+1)'(N - 1);

    logic [LW:0] cnt_q, base;

    assign base = restart ? '0 : cnt_q;
    assign pos  = base[LW-1:0];
    assign fits = (base == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= (base == CNT_MAX) ? base : base + 1'b1;
        end
    end
endmodule

// File: rtl/selidx_classifier.sv
module selidx_classifier
    import selidx_pkg::*;
#(
    parameter int N  = 32,
    parameter int LW = $clog2(N),
    parameter int IW = LW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_first,
    input  logic          in_last,
    input  logic [IW-1:0] in_index,
    output logic          result_valid,
    output logic          is_extract,
    output logic          is_deposit,
    output logic [N-1:0]  mask
);
    cls_state_e    state_q, state_n;
    logic          take;
    logic [LW-1:0] pos;
    logic          fits, len_ok_q;
    logic          ext_ok, dep_ok;
    logic [N-1:0]  ext_mask, dep_mask;

    // An entry is taken when it opens a vector or continues an open one.
    assign take = in_valid && (in_first || state_q == ST_RUN);

    selidx_len_count #(.N(N), .LW(LW)) u_len (
        .clk(clk), .rst_n(rst_n), .take(take), .restart(in_first),
        .pos(pos), .fits(fits)
    );

    selidx_extract_track #(.N(N), .LW(LW), .IW(IW)) u_ext (
        .clk(clk), .rst_n(rst_n), .take(take), .restart(in_first),
        .idx(in_index), .ok(ext_ok), .mask(ext_mask)
    );

    selidx_deposit_track #(.N(N), .LW(LW), .IW(IW)) u_dep (
        .clk(clk), .rst_n(rst_n), .take(take), .restart(in_first),
        .idx(in_index), .pos(pos), .ok(dep_ok), .mask(dep_mask)
    );

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && in_first) state_n = in_last ? ST_DONE : ST_RUN;   // T_SINGLE / T_START
            end
            ST_RUN: begin
                if (in_valid && in_last) state_n = ST_DONE;                        // T_FINISH
                else                     state_n = ST_RUN;                         // T_ENTRY / T_RESTART
            end
            ST_DONE: begin
                if (in_valid && in_first) state_n = in_last ? ST_DONE : ST_RUN;   // T_SINGLE / T_RELOAD
                else                      state_n = ST_IDLE;                       // T_RETIRE
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register and length verdict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            len_ok_q <= 1'b0;
        end else begin
            state_q <= state_n;
            if (take && in_last) len_ok_q <= fits;
        end
    end

    // Outputs
    always_comb begin
        result_valid = 1'b0;
        is_extract   = 1'b0;
        is_deposit   = 1'b0;
        mask         = '0;
        unique case (state_q)
            ST_DONE: begin
                result_valid = 1'b1;
                is_extract   = ext_ok && len_ok_q;
                is_deposit   = dep_ok && len_ok_q;
                if (is_deposit)      mask = dep_mask;
                else if (is_extract) mask = ext_mask;
            end
            ST_IDLE, ST_RUN: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/selidx_classifier_chk.sv
module selidx_classifier_chk #(
    parameter int N  = 32,
    parameter int IW = $clog2(N) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_first,
    input logic          in_last,
    input logic [IW-1:0] in_index,
    input logic          result_valid,
    input logic          is_extract,
    input logic          is_deposit,
    input logic [N-1:0]  mask
);
    // R7
    rv_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(in_valid && in_last));

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> (!result_valid || $past(in_valid && in_first && in_last)));

    // R7
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> (!is_extract && !is_deposit && mask == '0));

    // R7
    nomatch_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !is_extract && !is_deposit) |-> mask == '0);

    // R5
    dual_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_extract && is_deposit) |-> ((mask & (mask + 1'b1)) == '0));

    // R8
    index_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !$isunknown(in_index));
endmodule

bind selidx_classifier selidx_classifier_chk #(.N(N), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_index(in_index), .result_valid(result_valid),
    .is_extract(is_extract), .is_deposit(is_deposit), .mask(mask)
);

// File: tb/selidx_classifier_tb.sv
module selidx_classifier_tb;
    localparam int N       = 32;
    localparam int LW      = $clog2(N);
    localparam int IW      = LW + 1;
    localparam int CLK_PER = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
    logic [IW-1:0] in_index = '0;
    logic          result_valid, is_extract, is_deposit;
    logic [N-1:0]  mask;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;
    int  vq [0:2*N];

    always #(CLK_PER/2) clk = ~clk;

    selidx_classifier #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_index(in_index), .result_valid(result_valid),
        .is_extract(is_extract), .is_deposit(is_deposit), .mask(mask)
    );

    // Reference classifier following the requirement text.
    task automatic model(input int len, output bit e, output bit d, output logic [N-1:0] m);
        bit tail = 0;
        int prev = -1;
        int nxt  = 0;
        logic [N-1:0] em = '0, dm = '0;
        e = 1; d = 1;
        for (int i = 0; i < len; i++) begin
            if (vq[i] < N) begin
                if (tail || vq[i] <= prev) e = 0;
                else begin em[vq[i]] = 1'b1; prev = vq[i]; end
                if (vq[i] != nxt) d = 0;
                if (i < N) dm[i] = 1'b1;
                nxt++;
            end else begin
                tail = 1;
                if (vq[i] != N) d = 0;
            end
        end
        if (len != N) begin e = 0; d = 0; end
        m = d ? dm : (e ? em : '0);
    endtask

    function automatic logic [N-1:0] rand_mask(input int density);
        logic [N-1:0] r = '0;
        for (int b = 0; b < N; b++) r[b] = ($urandom_range(0, 99) < density);
        return r;
    endfunction

    function automatic int build_ext(input logic [N-1:0] m, input bit noncanon);
        int k = 0;
        for (int b = 0; b < N; b++) if (m[b]) begin vq[k] = b; k++; end
        for (int i = k; i < N; i++) vq[i] = noncanon ? int'($urandom_range(N, 2*N-1)) : N;
        return k;
    endfunction

    function automatic void build_dep(input logic [N-1:0] m);
        int c = 0;
        for (int i = 0; i < N; i++) begin
            if (m[i]) begin vq[i] = c; c++; end
            else vq[i] = N;
        end
    endfunction

    task automatic drive_vec(input int len, input bit gaps);
        for (int i = 0; i < len; i++) begin
            if (gaps && $urandom_range(0, 3) == 0) begin
                in_valid = 1'b0; in_index = IW'($urandom_range(0, 2*N-1));
                in_first = 1'b1; in_last = 1'b1;
                @(negedge clk);
            end
            in_valid = 1'b1; in_first = (i == 0); in_last = (i == len - 1);
            in_index = IW'(vq[i]);
            @(negedge clk);
        end
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    endtask

    task automatic drive_junk(input int n, input bit with_first);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1; in_first = with_first && (i == 0); in_last = 1'b0;
            in_index = IW'($urandom_range(0, 2*N-1));
            @(negedge clk);
        end
        in_valid = 1'b0; in_first = 1'b0;
    endtask

    // Sample the verdict cycle, then the following cycle.
    task automatic check_now(input string req, input bit ee, input bit ed, input logic [N-1:0] em);
        bit rv1, x1, d1, rv2;
        logic [N-1:0] m1;
        rv1 = result_valid; x1 = is_extract; d1 = is_deposit; m1 = mask;
        @(negedge clk);
        rv2 = result_valid;
        n_chk++;
        if (!(rv1 && !rv2 && x1 == ee && d1 == ed && m1 === em)) begin
            n_bad++;
            $display("FAIL %s: rv=%0b/%0b ext=%0b dep=%0b mask=%h, expected rv=1/0 ext=%0b dep=%0b mask=%h",
                     req, rv1, rv2, x1, d1, m1, ee, ed, em);
        end
    endtask

    task automatic run_vec(input string req, input int len, input bit gaps);
        bit e, d;
        logic [N-1:0] m;
        model(len, e, d, m);
        drive_vec(len, gaps);
        check_now(req, e, d, m);
    endtask

    initial begin
        logic [N-1:0] rm;
        int k, t;
        void'($urandom(32'h1D5E_A11));
        repeat (3) @(negedge clk);
        // R7: reset state
        n_chk++;
        if (result_valid || is_extract || is_deposit || mask != '0) begin
            n_bad++;
            $display("FAIL R7 reset: rv=%0b ext=%0b dep=%0b mask=%h, expected all 0",
                     result_valid, is_extract, is_deposit, mask);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1: worked example
        vq[0] = 0; vq[1] = 2; vq[2] = 5; vq[3] = 6;
        for (int i = 4; i < N; i++) vq[i] = N;
        drive_vec(N, 0);
        check_now("R1 example", 1'b1, 1'b0, N'(32'h65));

        // R3: worked example
        for (int i = 0; i < N; i++) vq[i] = N;
        vq[0] = 0; vq[2] = 1; vq[5] = 2; vq[6] = 3;
        drive_vec(N, 0);
        check_now("R3 example", 1'b0, 1'b1, N'(32'h65));

        // R5: all-zero and identity
        for (int i = 0; i < N; i++) vq[i] = N;
        drive_vec(N, 0);
        check_now("R5 zeros", 1'b1, 1'b1, '0);
        for (int i = 0; i < N; i++) vq[i] = i;
        drive_vec(N, 0);
        check_now("R5 identity", 1'b1, 1'b1, '1);

        // R6: wrong lengths
        for (int i = 0; i <= N; i++) vq[i] = N;
        drive_vec(N - 1, 0);
        check_now("R6 short", 1'b0, 1'b0, '0);
        drive_vec(N + 1, 0);
        check_now("R6 long", 1'b0, 1'b0, '0);
        drive_vec(1, 0);
        check_now("R6 single", 1'b0, 1'b0, '0);

        // R8: junk before first, restart mid-vector
        drive_junk(5, 0);
        vq[0] = 0; vq[1] = 2; vq[2] = 5; vq[3] = 6;
        for (int i = 4; i < N; i++) vq[i] = N;
        drive_vec(N, 1);
        check_now("R8 junk before first", 1'b1, 1'b0, N'(32'h65));
        drive_junk(11, 1);
        run_vec("R8 restart", N, 0);

        for (int r = 0; r < 40; r++) begin
            rm = rand_mask(10 + 20 * (r % 5));
            // R1: extract from random mask, any zero selector
            k = build_ext(rm, r[0]);
            run_vec("R1 random extract", N, r[1]);
            // R2: swap or repeat
            if (k >= 2) begin
                t = $urandom_range(0, k - 2);
                if (r[2]) begin int s = vq[t]; vq[t] = vq[t+1]; vq[t+1] = s; end
                else vq[t+1] = vq[t];
                run_vec("R2 swapped/repeated", N, 0);
            end
            // R2: data index after a zero
            if (k < N) begin
                k = build_ext(rm, 0);
                vq[N-1] = $urandom_range(0, N - 1);
                run_vec("R2 data in tail", N, 0);
            end
            // R3: deposit from random mask
            build_dep(rm);
            run_vec("R3 random deposit", N, r[3]);
            // R4: gap in data order or non-canonical zero
            build_dep(rm);
            t = $urandom_range(0, N - 1);
            if (r[1]) begin
                for (int i = t; i < N; i++) if (vq[i] < N && vq[i] > 0) vq[i] = vq[i] + 1;
                for (int i = 0; i < N; i++) if (vq[i] == N && i > t) vq[i] = N;
            end else if (vq[t] >= N) vq[t] = $urandom_range(N + 1, 2*N - 1);
            else vq[t] = vq[t] + 1;
            for (int i = 0; i < N; i++) if (vq[i] > 2*N - 1) vq[i] = 2*N - 1;
            run_vec("R4 corrupted deposit", N, 0);
        end

        // R8: fully random vectors with idle gaps
        for (int r = 0; r < 20; r++) begin
            for (int i = 0; i < N; i++) vq[i] = $urandom_range(0, 2*N - 1);
            run_vec("R8 random gaps", N, 1);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule